// File: doc/BRIEF.md
# Parallel Instrument Bus Access Sequencer

This block carries out one register access on a shared 8-bit parallel instrument bus that normally belongs to a resident controller. A single command names a direction, a 7-bit register address and, for a write, one byte of data. The sequencer then takes the bus by pulling a takeover line and an active-low buffer-enable line low. It places the address on the bus with bit 7 showing the direction: 0 for a write and 1 for a read. That bit also steers the external data buffers. For a write it also drives the data byte.

After a setup interval the sequencer raises an address-valid strobe. For a write the strobe stays high for a fixed width. For a read it stays high until a sample point, where the byte on the data bus is captured. After the strobe falls, a hold interval follows. The sequencer then lets the address and data buses float for one cycle, hands the control lines back to the resident controller, and pulses a done flag.

All intervals are counted in clock cycles and set by parameters. The block takes one command at a time. While an access is running it holds its ready output low and ignores further commands.

Top module: `ibm_top`

## Requirements
- R1: After reset the takeover and buffer-enable lines are high, the strobe is low, both buses are released (high impedance), ready is high, done is low and the read data is 0.
- R2: In the cycle after a command is accepted (valid while ready), takeover and buffer-enable go low and the address bus carries {direction, address}, with bit 7 = 0 for a write and 1 for a read. The strobe stays low in that cycle.
- R3: For a write, the data bus carries the write byte from the first access cycle to the last hold cycle. The strobe is high for exactly STROBE_CYC consecutive cycles.
- R4: The strobe rises only after exactly SETUP_CYC cycles in which the bus is owned and the address (and any write data) is driven.
- R5: After the strobe falls, the address (and any write data) stays driven for exactly HOLD_CYC cycles.
- R6: For a read the block never drives the data bus. The strobe is high for exactly SAMPLE_CYC cycles, and rdData takes the data bus value from the last strobe-high cycle.
- R7: After the hold interval the address and data buses are released for exactly one cycle while takeover stays low. In the next cycle takeover and buffer-enable are high and done is high for that one cycle only.
- R8: Ready is low from the cycle after acceptance until the cycle after done. A command presented while ready is low has no effect on the running access and starts no further access.
- R9: rdData changes only when a read samples the bus. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command request |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | 7 | Register address |
| cmdWdata | input | 8 | Write byte |
| cmdReady | output | 1 | Idle, able to accept a command |
| rdData | output | 8 | Last byte sampled by a read |
| done | output | 1 | One-cycle pulse when the bus is handed back |
| addrBus | output | 8 | Address bus, bit 7 = direction, high impedance when released |
| dataBus | inout | 8 | Bidirectional data bus |
| busGrabN | output | 1 | Bus takeover, low while the sequencer owns the bus |
| bufEnN | output | 1 | Data buffer enable, active low |
| strobe | output | 1 | Address-valid strobe, active high |

## Verification
The bench runs writes and reads against a model of a 128-register instrument. Write-then-read pairs show that bit 7 and the strobe edges are placed correctly: a wrong edge or direction bit leaves the register unwritten or returns the wrong byte. A read of a preloaded register that was never written separates real sampling from stale data. A write of 0x00 separates a driven bus from a released bus, which reads 0xFF through the pull-ups.

Every access is profiled cycle by cycle, so an error of one cycle in setup, strobe width, hold or release shows up as a count mismatch. One run keeps the command valid with a different address for the whole access, to show that busy-time commands are ignored.

// File: rtl/ibm_pkg.sv
package ibm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RELEASE,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch the command
    logic capture;  // sample the data bus into rdData
    logic addrOe;   // drive the address bus
    logic dataOe;   // drive the data bus
    logic strobe;   // address-valid strobe level
    logic grab;     // own the bus (takeover and buffer enable)
  } ctlStrobes_t;

endpackage

// File: rtl/ibm_ctrl.sv
module ibm_ctrl
  import ibm_pkg::*;
#(
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 40,
  parameter int SAMPLE_CYC = 12,
  parameter int HOLD_CYC   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  output logic        cmdReady,
  output logic        done,
  output ctlStrobes_t ctl
);

  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD = (SAMPLE_CYC > HOLD_CYC) ? SAMPLE_CYC : HOLD_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seqState_t state;
  logic [CNT_W-1:0] cnt;
  logic opWrite;
  logic cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            state   <= ST_SETUP;
            cnt     <= CNT_W'(SETUP_CYC - 1);
            opWrite <= cmdWrite;
          end
        end
        ST_SETUP: begin
          if (cntZero) begin
            state <= ST_STROBE;
            cnt   <= opWrite ? CNT_W'(STROBE_CYC - 1) : CNT_W'(SAMPLE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cntZero) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cntZero) state <= ST_RELEASE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_RELEASE: state <= ST_FINISH;
        ST_FINISH:  state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && cmdValid;
    ctl.capture = (state == ST_STROBE) && !opWrite && cntZero;
    ctl.addrOe  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    ctl.dataOe  = ctl.addrOe && opWrite;
    ctl.strobe  = (state == ST_STROBE);
    ctl.grab    = ctl.addrOe || (state == ST_RELEASE);
  end

  assign cmdReady = (state == ST_IDLE);
  assign done     = (state == ST_FINISH);

endmodule

// File: rtl/ibm_dpath.sv
module ibm_dpath
  import ibm_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [DATA_W-1:0] rdData,
  output wire  [ADDR_W:0]   addrBus,
  inout  wire  [DATA_W-1:0] dataBus,
  output logic              busGrabN,
  output logic              bufEnN,
  output logic              strobe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (ctl.load) begin
      addrQ  <= cmdAddr;
      wdataQ <= cmdWdata;
      writeQ <= cmdWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= dataBus;
  end

  // top address bit: 1 = read, steers the external buffers
  assign addrBus  = ctl.addrOe ? {~writeQ, addrQ} : 'z;
  assign dataBus  = ctl.dataOe ? wdataQ : 'z;
  assign busGrabN = ~ctl.grab;
  assign bufEnN   = ~ctl.grab;
  assign strobe   = ctl.strobe;

endmodule

// File: rtl/ibm_top.sv
module ibm_top
  import ibm_pkg::*;
#(
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 40,
  parameter int SAMPLE_CYC = 12,
  parameter int HOLD_CYC   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic [6:0] cmdAddr,
  input  logic [7:0] cmdWdata,
  output logic       cmdReady,
  output logic [7:0] rdData,
  output logic       done,
  output wire  [7:0] addrBus,
  inout  wire  [7:0] dataBus,
  output logic       busGrabN,
  output logic       bufEnN,
  output logic       strobe
);

  ctlStrobes_t ctl;

  ibm_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .SAMPLE_CYC(SAMPLE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdWrite(cmdWrite),
    .cmdReady(cmdReady),
    .done    (done),
    .ctl     (ctl)
  );

  ibm_dpath #(
    .ADDR_W(7),
    .DATA_W(8)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cmdWrite(cmdWrite),
    .cmdAddr (cmdAddr),
    .cmdWdata(cmdWdata),
    .rdData  (rdData),
    .addrBus (addrBus),
    .dataBus (dataBus),
    .busGrabN(busGrabN),
    .bufEnN  (bufEnN),
    .strobe  (strobe)
  );

endmodule

// File: rtl/ibm_chk.sv
module ibm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdReady,
  input logic       done,
  input logic       busGrabN,
  input logic       bufEnN,
  input logic       strobe,
  input logic [7:0] rdData
);

  p_strobe_owned_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> (!busGrabN && !bufEnN));

  p_setup_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe) |-> $past(!busGrabN));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_handback_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busGrabN && bufEnN && !strobe && $past(!busGrabN)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (busGrabN && !done && !strobe));

  p_rd_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> $stable(rdData));

endmodule

bind ibm_top ibm_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdReady(cmdReady),
  .done    (done),
  .busGrabN(busGrabN),
  .bufEnN  (bufEnN),
  .strobe  (strobe),
  .rdData  (rdData)
);

// File: tb/sim_ibm_top.sv
`timescale 1ns/1ps
module sim_ibm_top;

  localparam int SETUP_N  = 4;
  localparam int WIDTH_W  = 40;
  localparam int WIDTH_R  = 12;
  localparam int HOLD_N   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [6:0] cmdAddr = '0;
  logic [7:0] cmdWdata = '0;
  logic       cmdReady;
  logic [7:0] rdData;
  logic       done;
  wire  [7:0] addrBus;
  wire  [7:0] dataBus;
  logic       busGrabN;
  logic       bufEnN;
  logic       strobe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ibm_top u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdReady(cmdReady),
    .rdData(rdData), .done(done), .addrBus(addrBus), .dataBus(dataBus),
    .busGrabN(busGrabN), .bufEnN(bufEnN), .strobe(strobe)
  );

  // released buses read as 0xFF
  for (genvar g = 0; g < 8; g++) begin : g_pull
    pullup (dataBus[g]);
    pullup (addrBus[g]);
  end

  // instrument model: 128 registers
  logic [7:0] regs [128];
  initial for (int i = 0; i < 128; i++) regs[i] = 8'(i) ^ 8'hA5;
  assign dataBus = (strobe && addrBus[7] && !busGrabN) ? regs[addrBus[6:0]] : 8'hzz;
  always @(negedge strobe) if (!addrBus[7]) regs[addrBus[6:0]] = dataBus;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [6:0] a, input logic [7:0] d,
                        input logic [7:0] expRd, input bit pester);
    int setN = 0, hiN = 0, holdN = 0, relN = 0, n = 0;
    int badAddr = 0, badData = 0, badReady = 0;
    bit seenHi = 0;
    logic [7:0] expAddr = {~wr, a};
    logic [7:0] rdBefore = rdData;
    @(negedge clk);
    cmdValid = 1; cmdWrite = wr; cmdAddr = a; cmdWdata = d;
    @(posedge clk);
    @(negedge clk);
    if (pester) begin cmdWrite = ~wr; cmdAddr = a ^ 7'h15; cmdWdata = ~d; end
    else cmdValid = 0;
    check(!busGrabN && !bufEnN && !strobe && addrBus == expAddr, "R2",
          int'(addrBus), int'(expAddr));
    while (!done && n < 500) begin
      n++;
      if (cmdReady) badReady++;
      if (strobe) begin
        hiN++; seenHi = 1;
        if (addrBus != expAddr) badAddr++;
        if (wr && dataBus != d) badData++;
      end else if (!busGrabN && addrBus == expAddr) begin
        if (seenHi) holdN++; else setN++;
        if (wr && dataBus != d) badData++;
        if (!wr && dataBus != 8'hFF) badData++;
      end else if (!busGrabN && addrBus == 8'hFF && dataBus == 8'hFF) begin
        relN++;
      end else badAddr++;
      @(negedge clk);
    end
    cmdValid = 0;
    check(done && busGrabN && bufEnN, "R7 done handback", int'(done), 1);
    check(setN == SETUP_N, "R4 setup", setN, SETUP_N);
    check(hiN == (wr ? WIDTH_W : WIDTH_R), wr ? "R3 width" : "R6 width",
          hiN, wr ? WIDTH_W : WIDTH_R);
    check(holdN == HOLD_N, "R5 hold", holdN, HOLD_N);
    check(relN == 1, "R7 release", relN, 1);
    check(badAddr == 0, "R2 addr", badAddr, 0);
    check(badData == 0, wr ? "R3 data" : "R6 no drive", badData, 0);
    check(badReady == 0, "R8 ready", badReady, 0);
    if (wr) check(rdData == rdBefore, "R9", int'(rdData), int'(rdBefore));
    else    check(rdData == expRd, "R6 rddata", int'(rdData), int'(expRd));
    @(negedge clk);
    check(!done && cmdReady, "R7 pulse", int'(done), 0);
    if (pester) begin
      for (int k = 0; k < 6; k++) begin
        check(busGrabN && cmdReady, "R8 ignored", int'(busGrabN), 1);
        @(negedge clk);
      end
      check(regs[a ^ 7'h15] == ((a ^ 7'h15) ^ 8'hA5), "R8 no write",
            int'(regs[a ^ 7'h15]), int'((a ^ 7'h15) ^ 8'hA5));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busGrabN && bufEnN && !strobe && cmdReady && !done, "R1 ctrl",
          int'({busGrabN, bufEnN, strobe, cmdReady, done}), 5'b11010);
    check(addrBus == 8'hFF && dataBus == 8'hFF, "R1 buses", int'(addrBus), 8'hFF);
    check(rdData == 8'h00, "R1 rdData", int'(rdData), 0);
  endtask

  task automatic t_write_read();
    access(1, 7'h12, 8'h3C, 8'h00, 0);
    check(regs[7'h12] == 8'h3C, "R3 model", int'(regs[7'h12]), 8'h3C);
    access(0, 7'h12, 8'h00, 8'h3C, 0);
  endtask

  task automatic t_preloaded();
    access(0, 7'h40, 8'h00, 8'h40 ^ 8'hA5, 0);
    access(0, 7'h7E, 8'h00, 8'h7E ^ 8'hA5, 0);
  endtask

  task automatic t_zero_write();
    access(1, 7'h00, 8'h00, 8'h00, 0);
    check(regs[0] == 8'h00, "R3 zero", int'(regs[0]), 0);
    access(0, 7'h00, 8'h00, 8'h00, 0);
  endtask

  task automatic t_ignore();
    access(1, 7'h2A, 8'hC3, 8'h00, 1);
    check(regs[7'h2A] == 8'hC3, "R8 orig", int'(regs[7'h2A]), 8'hC3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    t_reset();
    t_write_read();
    t_preloaded();
    t_zero_write();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule